// File: doc/BRIEF.md
# Shared-Medium Transmit Access Controller

This block decides when a half-duplex transmitter may place a frame on a shared medium. A framer raises a request. The controller waits for carrier sense to go quiet and then counts an interframe gap before it grants the medium. If a collision is reported while the grant is held, the grant is withdrawn and a jam command is held for a fixed number of bit times. The attempt counter is then advanced and the controller waits a random backoff before it defers again.

The backoff is a whole number of slot times. The slot multiple is drawn from a free-running LFSR, masked to a range that doubles with every collision until a configured cap is reached. All timing is counted in bit-time ticks supplied from outside, so the same block serves a 10 Mb/s link (0.1 µs per tick) and a 100 Mb/s link (0.01 µs per tick). After a configured number of collisions the frame is dropped and a one-cycle abort is reported. A frame that ends with no collision clears the attempt count.

Top module: `csma_access_ctrl`

## Requirements
- R1: With `tx_req_i` high, `tx_grant_o` rises only after `carrier_i` has been low and `IFG_BITS` (default 96) further ticks have passed. With a tick on every clock, the grant appears 2 + IFG_BITS cycles after the request is raised on a quiet medium, and 1 + IFG_BITS cycles after the carrier falls if the medium was busy.
- R2: Carrier seen high during the gap count restarts deferral. The full gap is counted again from the next carrier fall.
- R3: All gap, jam and backoff timing advances only on cycles with `bit_tick_i` high. While the tick is held low, no grant is issued.
- R4: A collision while the grant is held drops the grant on the next cycle and holds `jam_o` for exactly `JAM_BITS` (default 512) ticks. If `collision_i` and `tx_done_i` arrive in the same cycle, the collision wins. A collision while no grant is held is ignored.
- R5: `attempts_o` increments by one on each collision of the current frame. The new value is visible in the first jam cycle.
- R6: After the n-th collision and its jam, the block waits k × `SLOT_BITS` ticks, with k drawn from an LFSR in 0 to 2^n − 1. It then defers and counts a full gap again before re-granting.
- R7: The exponent of the backoff range stops at `BACKOFF_LIMIT` (default 10, so k ≤ 1023).
- R8: `tx_done_i` while granted, with no collision, ends the frame: the grant drops and `attempts_o` returns to 0.
- R9: When the `MAX_ATTEMPTS`-th (default 16) collision's jam ends, `abort_o` pulses for one cycle, no grant is issued and `attempts_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| carrier_i | input | 1 | Carrier sense from the PHY |
| collision_i | input | 1 | Collision indication from the PHY |
| tx_req_i | input | 1 | Framer has a frame pending |
| tx_done_i | input | 1 | Framer finished sending the frame |
| tx_grant_o | output | 1 | Framer may transmit |
| jam_o | output | 1 | Framer must send the jam pattern |
| abort_o | output | 1 | One-cycle pulse: frame dropped after excessive collisions |
| attempts_o | output | $clog2(MAX_ATTEMPTS+1) | Collisions seen for the current frame |

## Verification
A corrupted state register or timer shows up at the ports as a grant or jam edge that is off by whole ticks. With the tick running every cycle, the bench counts the gap, jam and backoff intervals exactly. The backoff cannot be predicted at the ports, so the bench checks that it is a slot multiple and stays within the range allowed for the current collision count, including the capped range. A wrong attempt count appears in the first jam cycle, in the cycle after a successful frame, or as an abort that comes early or late.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_GAP,
    ST_XMIT,
    ST_JAM,
    ST_BACKOFF
  } csma_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int          OUT_W = 10,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  localparam logic [15:0] TAPS = 16'hB400;
  logic [15:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0);
  end

  assign rnd_o = lfsr_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != 16'h0); // R6
endmodule

// File: rtl/csma_tick_timer.sv
module csma_tick_timer #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_TIMER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/csma_backoff_sel.sv
module csma_backoff_sel #(
  parameter int LIMIT = 10,
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] attempts_i,
  input  logic [LIMIT-1:0] rnd_i,
  output logic [LIMIT-1:0] k_o
);
  int unsigned expo;
  logic [LIMIT-1:0] mask;

  always_comb begin
    expo = (int'(attempts_i) > LIMIT) ? LIMIT : int'(attempts_i);
  end

  for (genvar i = 0; i < LIMIT; i++) begin : g_mask
    assign mask[i] = (i < expo);
  end

  assign k_o = rnd_i & mask;
endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl
  import csma_pkg::*;
#(
  parameter int          IFG_BITS      = 96,
  parameter int          JAM_BITS      = 512,
  parameter int          SLOT_BITS     = 512,
  parameter int          BACKOFF_LIMIT = 10,
  parameter int          MAX_ATTEMPTS  = 16,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1,
  localparam int         CNT_W         = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             carrier_i,
  input  logic             collision_i,
  input  logic             tx_req_i,
  input  logic             tx_done_i,
  output logic             tx_grant_o,
  output logic             jam_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] attempts_o
);
  localparam int TMR_W = $clog2((2 ** BACKOFF_LIMIT) * SLOT_BITS + IFG_BITS + JAM_BITS + 1);
  localparam logic [TMR_W-1:0] GAP_END  = TMR_W'(IFG_BITS - 1);
  localparam logic [TMR_W-1:0] JAM_END  = TMR_W'(JAM_BITS - 1);
  localparam logic [TMR_W-1:0] SLOT_T   = TMR_W'(SLOT_BITS);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_ATTEMPTS);

  csma_state_e state_q, state_d;
  logic [CNT_W-1:0]         attempts_q;
  logic [BACKOFF_LIMIT-1:0] k_q, k_next, rnd;
  logic [TMR_W-1:0]         tcnt, bo_target;
  logic                     abort_q;
  logic                     coll_hit, frame_ok, give_up, jam_end;

  csma_lfsr #(.OUT_W(BACKOFF_LIMIT), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  csma_tick_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .tick_i (bit_tick_i),
    .cnt_o  (tcnt)
  );

  csma_backoff_sel #(.LIMIT(BACKOFF_LIMIT), .CNT_W(CNT_W)) u_bsel (
    .attempts_i (attempts_q),
    .rnd_i      (rnd),
    .k_o        (k_next)
  );

  assign bo_target = TMR_W'(k_q) * SLOT_T;
  assign jam_end   = (state_q == ST_JAM) && bit_tick_i && (tcnt == JAM_END);
  assign coll_hit  = (state_q == ST_XMIT) && collision_i;
  assign frame_ok  = (state_q == ST_XMIT) && !collision_i && tx_done_i;
  assign give_up   = jam_end && (attempts_q >= MAX_CNT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (tx_req_i) state_d = ST_DEFER;
      ST_DEFER: if (!carrier_i) state_d = ST_GAP;
      ST_GAP: begin
        if (carrier_i)                             state_d = ST_DEFER;
        else if (bit_tick_i && (tcnt == GAP_END))  state_d = ST_XMIT;
      end
      ST_XMIT: begin
        // collision outranks a done reported in the same cycle
        if (collision_i)    state_d = ST_JAM;
        else if (tx_done_i) state_d = ST_IDLE;
      end
      ST_JAM: begin
        if (jam_end) begin
          if (give_up)          state_d = ST_IDLE;
          else if (k_next == '0) state_d = ST_DEFER;
          else                  state_d = ST_BACKOFF;
        end
      end
      ST_BACKOFF: if (bit_tick_i && (tcnt == bo_target - 1'b1)) state_d = ST_DEFER;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      attempts_q <= '0;
      k_q        <= '0;
      abort_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= give_up;
      if (coll_hit)                attempts_q <= attempts_q + 1'b1;
      else if (frame_ok || give_up) attempts_q <= '0;
      if (jam_end) k_q <= k_next;
    end
  end

  assign tx_grant_o = (state_q == ST_XMIT);
  assign jam_o      = (state_q == ST_JAM);
  assign abort_o    = abort_q;
  assign attempts_o = attempts_q;

  AST_GRANT_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_grant_o) |-> !$past(carrier_i)); // R1
  AST_JAM_ON_COLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_grant_o && collision_i) |=> (jam_o && !tx_grant_o)); // R4
  AST_SUCCESS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_grant_o && tx_done_i && !collision_i) |=> (attempts_o == '0)); // R8
  AST_ATTEMPT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempts_o <= MAX_CNT); // R9
  AST_ABORT_AFTER_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(jam_o) && !jam_o && !tx_grant_o)); // R9
endmodule

// File: tb/tb_csma_access_ctrl.sv
module tb_csma_access_ctrl;
  localparam int IFG   = 6;
  localparam int JAM   = 4;
  localparam int SLOT  = 8;
  localparam int LIM   = 3;
  localparam int MAXA  = 6;
  localparam int CW    = $clog2(MAXA + 1);
  localparam int NVEC  = 5;
  // per-vector: collisions before success, carrier-busy cycles at request
  localparam int VEC_COLL [NVEC] = '{0, 1, 2, 4, 5};
  localparam int VEC_BUSY [NVEC] = '{0, 3, 0, 5, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b1, carrier = 1'b0, coll = 1'b0, req = 1'b0, done = 1'b0;
  logic grant, jam, abrt;
  logic [CW-1:0] att;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  csma_access_ctrl #(
    .IFG_BITS(IFG), .JAM_BITS(JAM), .SLOT_BITS(SLOT),
    .BACKOFF_LIMIT(LIM), .MAX_ATTEMPTS(MAXA)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .carrier_i(carrier),
    .collision_i(coll), .tx_req_i(req), .tx_done_i(done),
    .tx_grant_o(grant), .jam_o(jam), .abort_o(abrt), .attempts_o(att)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_grant(output int n);
    n = -1;
    for (int i = 1; i < 3000; i++) begin
      @(negedge clk);
      if (grant) begin n = i; break; end
    end
  endtask

  // collision pulse while granted; returns jam length, ends on jam-fall negedge
  task automatic collide(input int nth, output int jl);
    coll = 1'b1;
    @(negedge clk);
    coll = 1'b0;
    chk(jam && !grant, "R4 jam after collision", int'(jam), 1);
    chk(int'(att) == nth, "R5 attempt count", int'(att), nth);
    jl = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!jam) break;
      jl++;
    end
  endtask

  task automatic check_backoff(input int nth);
    int n, bo, cap, e;
    wait_grant(n);
    bo = n - 1 - IFG;
    e = (nth > LIM) ? LIM : nth;
    cap = ((1 << e) - 1) * SLOT;
    chk(n > 0 && bo >= 0 && (bo % SLOT) == 0, "R6 backoff slot multiple", bo, SLOT);
    if (nth > LIM) chk(bo <= cap, "R7 capped backoff range", bo, cap);
    else           chk(bo <= cap, "R6 backoff range", bo, cap);
  endtask

  initial begin
    int n, jl, exp;
    repeat (3) @(negedge clk);
    chk(!grant && !jam && !abrt && att == '0, "R1 reset outputs", int'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      carrier = (VEC_BUSY[v] > 0);
      req = 1'b1;
      if (VEC_BUSY[v] > 0) begin
        repeat (VEC_BUSY[v]) @(negedge clk);
        chk(!grant, "R1 no grant while carrier busy", int'(grant), 0);
        carrier = 1'b0;
        exp = 1 + IFG;
      end else exp = 2 + IFG;
      wait_grant(n);
      chk(n == exp, "R1 gap before grant", n, exp);
      for (int c = 1; c <= VEC_COLL[v]; c++) begin
        collide(c, jl);
        chk(jl == JAM, "R4 jam length", jl, JAM);
        check_backoff(c);
      end
      done = 1'b1; req = 1'b0;
      @(negedge clk);
      done = 1'b0;
      chk(!grant && att == '0, "R8 success clears attempts", int'(att), 0);
      repeat (2) @(negedge clk);
    end

    // R3: no progress without ticks
    tick = 1'b0; req = 1'b1;
    repeat (40) @(negedge clk);
    chk(!grant, "R3 no grant without ticks", int'(grant), 0);
    tick = 1'b1;
    wait_grant(n);
    chk(n == IFG, "R3 gap counted in ticks", n, IFG);
    done = 1'b1; req = 1'b0;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);

    // R2: carrier inside the gap restarts it
    req = 1'b1;
    repeat (4) @(negedge clk);
    carrier = 1'b1;
    @(negedge clk);
    chk(!grant, "R2 no grant on carrier", int'(grant), 0);
    carrier = 1'b0;
    wait_grant(n);
    chk(n == 1 + IFG, "R2 full gap after carrier", n, 1 + IFG);

    // R4: collision beats done in the same cycle
    coll = 1'b1; done = 1'b1;
    @(negedge clk);
    coll = 1'b0; done = 1'b0;
    chk(jam && !grant, "R4 collision over done", int'(jam), 1);
    chk(att == CW'(1), "R5 attempts after tie", int'(att), 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!jam) break;
    end
    check_backoff(1);
    done = 1'b1; req = 1'b0;
    @(negedge clk);
    done = 1'b0;
    chk(att == '0, "R8 clear after retry success", int'(att), 0);

    // R4: collisions without grant ignored
    coll = 1'b1;
    repeat (3) @(negedge clk);
    chk(!jam && att == '0, "R4 idle collision ignored", int'(jam), 0);
    req = 1'b1;
    repeat (3) @(negedge clk);
    chk(!jam && !grant && att == '0, "R4 gap collision ignored", int'(att), 0);
    coll = 1'b0;
    wait_grant(n);
    chk(n > 0, "R1 grant after ignored collisions", n, 1);

    // R9: excessive collisions
    for (int c = 1; c <= MAXA; c++) begin
      collide(c, jl);
      if (c < MAXA) begin
        wait_grant(n);
        chk(n > 0, "R6 retry granted", n, 1);
      end
    end
    chk(abrt == 1'b1, "R9 abort pulse", int'(abrt), 1);
    chk(att == '0 && !grant, "R9 attempts cleared on abort", int'(att), 0);
    req = 1'b0;
    @(negedge clk);
    chk(abrt == 1'b0, "R9 abort single cycle", int'(abrt), 0);
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (grant) n++;
    end
    chk(n == 0, "R9 no grant after abort", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule